// File: doc/BRIEF.md
# Two-Address ALU with Status Flag Update

This block is the execute-stage arithmetic and logic unit of a small 16-bit two-address core. Each issued operation takes a destination operand and a source operand, and the result replaces the destination. Instruction decode is done before this block. It hands over a 4-bit operation code and the two operand words. For immediate forms, the decoder has already placed the immediate in the source operand. The block returns the result, a destination write-enable and a strobe that marks a completed issue. All three are registered one clock after issue.

The block also holds a five-bit processor status register. Only add, subtract and compare may change it, and each of these changes only its own subset of bits. Every other bit keeps its value. The status bits leave the block as a port for a later branch-condition checker. Flags are produced for both the signed and the unsigned reading of the operands.

Top module: `alu_psr_unit`

## Requirements
- R1: While `rst` is high and after it falls, before any issue, `psr_out` is 0, `wr_en` is 0 and `res_valid` is 0.
- R2: Op code 0 (add) gives `result` = dst + src modulo 2^16 with `wr_en`=1, one clock after the issue edge.
- R3: Op code 1 (subtract) gives `result` = dst - src modulo 2^16 with `wr_en`=1.
- R4: The status word is laid out as bit 4 F, bit 3 L, bit 2 C, bit 1 N, bit 0 Z. Add sets C to the unsigned carry out, and subtract sets C to the unsigned borrow (dst < src). Both set F to signed overflow. Both keep L, N and Z.
- R5: Op code 2 (compare) sets Z when dst == src, L when dst < src unsigned and N when dst < src signed. It keeps C and F and asserts no `wr_en`.
- R6: Op codes 3, 4 and 5 give dst AND, OR and XOR src. Op code 6 (move) gives src. All of these write.
- R7: Op code 7 (load upper) gives src[7:0] in the upper byte and zero in the lower byte, and writes.
- R8: Op code 8 (shift) moves dst one bit and fills with zero. It shifts left when src[15] is 0 and right when src[15] is 1. It writes.
- R9: Op codes 3 to 8 leave `psr_out` unchanged.
- R10: Op codes 9 to 15, and any cycle with `in_valid` low, give `wr_en`=0 and `res_valid` low for reserved codes. They leave `psr_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 4 | Operation code |
| dst_operand | input | 16 | Destination operand, overwritten by the result |
| src_operand | input | 16 | Source operand or prepared immediate |
| res_valid | output | 1 | A defined operation completed |
| wr_en | output | 1 | Write `result` into the destination register |
| result | output | 16 | Operation result |
| psr_out | output | 5 | Status bits {F,L,C,N,Z} |

## Verification
Random operand pairs are driven through every op code, including the reserved ones. A per-operation model checks the result, the write-enable and all five status bits, so a flag that moves when it should not is caught as well as a wrong value. Directed pairs sit on the arithmetic edges: 0x7FFF+1 and 0x8000-1 show overflow without carry, and 0xFFFF+1 and 0-1 show carry and borrow without overflow. A compare of 0x8000 with 0x0001 sets N without L, which tells the signed relation from the unsigned one. A compare of equal words shows Z. Shifts run in both directions on patterns with set edge bits, which shows the zero fill.

// File: rtl/alu_psr_pkg.sv
package alu_psr_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_MOV = 4'd6,
    OP_LUI = 4'd7,
    OP_LSH = 4'd8
  } alu_op_e;

  localparam int PSR_W = 5;
  localparam int PSR_F = 4;
  localparam int PSR_L = 3;
  localparam int PSR_C = 2;
  localparam int PSR_N = 1;
  localparam int PSR_Z = 0;

  function automatic logic op_writes(input logic [3:0] op);
    return (op <= 4'd8) && (op != 4'd2);
  endfunction
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              ovf,
  output logic              eq,
  output logic              ult,
  output logic              slt
);
  localparam int MSB = DATA_W - 1;
  logic [DATA_W:0] wide;

  always_comb begin
    if (sub) wide = {1'b0, dst} - {1'b0, src};
    else     wide = {1'b0, dst} + {1'b0, src};
    sum   = wide[MSB:0];
    carry = wide[DATA_W];
    if (sub) ovf = (dst[MSB] != src[MSB]) && (sum[MSB] != dst[MSB]);
    else     ovf = (dst[MSB] == src[MSB]) && (sum[MSB] != dst[MSB]);
    eq  = (dst == src);
    ult = (dst < src);
    slt = ($signed(dst) < $signed(src));
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_psr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] res
);
  localparam int HALF_W = DATA_W / 2;
  localparam int MSB    = DATA_W - 1;

  always_comb begin
    case (op)
      OP_AND:  res = dst & src;
      OP_OR:   res = dst | src;
      OP_XOR:  res = dst ^ src;
      OP_MOV:  res = src;
      OP_LUI:  res = {src[HALF_W-1:0], {(DATA_W-HALF_W){1'b0}}};
      OP_LSH:  res = src[MSB] ? {1'b0, dst[MSB:1]} : {dst[MSB-1:0], 1'b0};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/psr_reg.sv
module psr_reg
  import alu_psr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_cf,
  input  logic             upd_lnz,
  input  logic             c_in,
  input  logic             f_in,
  input  logic             l_in,
  input  logic             n_in,
  input  logic             z_in,
  output logic [PSR_W-1:0] psr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      psr <= '0;
    end else begin
      if (upd_cf) begin
        psr[PSR_C] <= c_in;
        psr[PSR_F] <= f_in;
      end
      if (upd_lnz) begin
        psr[PSR_L] <= l_in;
        psr[PSR_N] <= n_in;
        psr[PSR_Z] <= z_in;
      end
    end
  end

  p_keep_cf_r5: assert property (@(posedge clk) disable iff (rst)
    !upd_cf |=> ($stable(psr[PSR_C]) && $stable(psr[PSR_F])));
  p_keep_lnz_r4: assert property (@(posedge clk) disable iff (rst)
    !upd_lnz |=> ($stable(psr[PSR_L]) && $stable(psr[PSR_N]) && $stable(psr[PSR_Z])));
endmodule

// File: rtl/alu_psr_unit.sv
module alu_psr_unit
  import alu_psr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] dst_operand,
  input  logic [DATA_W-1:0] src_operand,
  output logic              res_valid,
  output logic              wr_en,
  output logic [DATA_W-1:0] result,
  output logic [PSR_W-1:0]  psr_out
);
  logic [DATA_W-1:0] arith_sum, logic_res, next_res;
  logic carry, ovf, eq, ult, slt;
  logic is_arith, is_cmp, do_write, is_defined;

  always_comb begin
    is_arith   = (op_code == OP_ADD) || (op_code == OP_SUB);
    is_cmp     = (op_code == OP_CMP);
    is_defined = (op_code <= 4'd8);
    do_write   = in_valid && op_writes(op_code);
    next_res   = is_arith ? arith_sum : logic_res;
  end

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .dst(dst_operand), .src(src_operand), .sub(op_code != OP_ADD),
    .sum(arith_sum), .carry(carry), .ovf(ovf), .eq(eq), .ult(ult), .slt(slt)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op(op_code), .dst(dst_operand), .src(src_operand), .res(logic_res)
  );

  psr_reg u_psr (
    .clk(clk), .rst(rst),
    .upd_cf(in_valid && is_arith), .upd_lnz(in_valid && is_cmp),
    .c_in(carry), .f_in(ovf), .l_in(ult), .n_in(slt), .z_in(eq),
    .psr(psr_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      wr_en     <= 1'b0;
      result    <= '0;
    end else begin
      res_valid <= in_valid && is_defined;
      wr_en     <= do_write;
      if (do_write) result <= next_res;
    end
  end

  p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OP_CMP) |=> !wr_en);
  p_cmp_equal_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OP_CMP && dst_operand == src_operand) |=> psr_out[PSR_Z]);
  p_psr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || op_code > OP_CMP) |=> $stable(psr_out));
  p_idle_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!wr_en && !res_valid));
  p_write_valid_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> res_valid);
endmodule

// File: tb/alu_psr_unit_tb_top.sv
module alu_psr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [15:0] dst_operand = '0, src_operand = '0;
  logic        res_valid, wr_en;
  logic [15:0] result;
  logic [4:0]  psr_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [4:0] exp_psr = '0;

  always #2.5 clk = ~clk;

  alu_psr_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .dst_operand(dst_operand), .src_operand(src_operand),
    .res_valid(res_valid), .wr_en(wr_en), .result(result), .psr_out(psr_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R5";
      4'd3, 4'd4, 4'd5, 4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [15:0] model_res(input logic [3:0] op, input logic [15:0] d, input logic [15:0] s);
    case (op)
      4'd0: return d + s;
      4'd1: return d - s;
      4'd3: return d & s;
      4'd4: return d | s;
      4'd5: return d ^ s;
      4'd6: return s;
      4'd7: return {s[7:0], 8'h00};
      4'd8: return s[15] ? (d >> 1) : (d << 1);
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [4:0] model_psr(input logic [4:0] p, input logic [3:0] op,
                                          input logic [15:0] d, input logic [15:0] s);
    logic [4:0] n;
    logic [16:0] w;
    logic [15:0] r;
    n = p;
    if (op == 4'd0) begin
      w = {1'b0, d} + {1'b0, s}; r = w[15:0];
      n[2] = w[16];
      n[4] = (d[15] == s[15]) && (r[15] != d[15]);
    end else if (op == 4'd1) begin
      r = d - s;
      n[2] = (d < s);
      n[4] = (d[15] != s[15]) && (r[15] != d[15]);
    end else if (op == 4'd2) begin
      n[0] = (d == s);
      n[3] = (d < s);
      n[1] = ($signed(d) < $signed(s));
    end
    return n;
  endfunction

  task automatic issue(input bit v, input logic [3:0] op, input logic [15:0] d, input logic [15:0] s);
    bit exp_wr, exp_rv;
    logic [15:0] exp_r;
    string rq;
    @(negedge clk);
    in_valid = v; op_code = op; dst_operand = d; src_operand = s;
    exp_wr = v && (op <= 4'd8) && (op != 4'd2);
    exp_rv = v && (op <= 4'd8);
    exp_r  = model_res(op, d, s);
    if (v) exp_psr = model_psr(exp_psr, op, d, s);
    rq = v ? req_of(op) : "R10";
    @(negedge clk);
    check(wr_en == exp_wr, rq, "wr_en", {15'b0, wr_en}, {15'b0, exp_wr});
    check(res_valid == exp_rv, rq, "res_valid", {15'b0, res_valid}, {15'b0, exp_rv});
    if (exp_wr) check(result == exp_r, rq, "result", result, exp_r);
    check(psr_out == exp_psr, (op <= 4'd2 && v) ? "R4/R5" : "R9", "psr", {11'b0, psr_out}, {11'b0, exp_psr});
    in_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(psr_out == 5'b0 && !wr_en && !res_valid, "R1", "reset state",
          {11'b0, psr_out}, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    check(psr_out == 5'b0 && !wr_en && !res_valid, "R1", "after reset",
          {9'b0, wr_en, res_valid, psr_out}, 16'h0);
    // R2/R4 add corners
    issue(1, 4'd0, 16'h7FFF, 16'h0001);
    issue(1, 4'd0, 16'hFFFF, 16'h0001);
    issue(1, 4'd0, 16'h8000, 16'h8000);
    // R3/R4 subtract corners
    issue(1, 4'd1, 16'h8000, 16'h0001);
    issue(1, 4'd1, 16'h0000, 16'h0001);
    // R5 compare corners
    issue(1, 4'd2, 16'h8000, 16'h0001);
    issue(1, 4'd2, 16'h1234, 16'h1234);
    issue(1, 4'd2, 16'h0001, 16'hFFFF);
    // R6/R7/R8/R9 directed
    issue(1, 4'd3, 16'hF0F0, 16'h3C3C);
    issue(1, 4'd6, 16'h0000, 16'hBEEF);
    issue(1, 4'd7, 16'h5555, 16'hAB5A);
    issue(1, 4'd8, 16'h8001, 16'h0001);
    issue(1, 4'd8, 16'h8001, 16'h8000);
    // R10 reserved and idle
    issue(1, 4'd12, 16'hFFFF, 16'h0001);
    issue(0, 4'd0, 16'hFFFF, 16'h0001);
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      op = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'($urandom % 9);
      issue(($urandom % 10) != 0, op, 16'($urandom), 16'($urandom));
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule